// File: doc/BRIEF.md
# Dual-Path Read Return Merger

The block sits in front of a processor core and merges read-return beats from two sources onto one return channel. The first source is the shared internal bus. It returns line fills from slow targets such as boot flash or a host bridge. Every fill is a full line of `LINE_WORDS` words, delivered critical word first and wrapping around the line. The second source is a private path from the memory controller. It returns bursts of one word up to a full line, and each beat already carries its word index and an end-of-burst flag.

Private-path beats take precedence. A private burst can cut into an internal-bus line fill at any beat boundary. Once it has started, it runs to its end without interruption. The fill it displaced then picks up at the next word in wrap order. For each fill, the block keeps the first word index and a count of the beats already sent, so the resumed fill loses, repeats or corrupts no word. A critical case is a fill whose first beat leaves exactly one clock before a private beat arrives. That case must produce the same complete line.

Each source feeds a buffer one line deep, so a source that is held off can wait without dropping beats. A port-enable input shuts the private path off. Its traffic is then expected on the internal bus, and no preemption can take place. Every beat sent to the core is labelled with its source, transaction tag, word index and a last flag.

Top module: `rrm_return_merge`

## Requirements
- R1: After reset, `out_valid_o` is low, `bus_ready_o` is high, and `priv_ready_o` equals `priv_en_i`.
- R2: An internal-bus fill with start index s produces exactly `LINE_WORDS` output beats. Beat n carries word index (s + n) mod `LINE_WORDS` and the fill's tag. `out_last_o` is high only on beat n = `LINE_WORDS`-1.
- R3: At every point where the output register takes a new beat and both buffers hold a beat, the private beat is chosen.
- R4: From the first beat of a private burst until its beat with the last flag, no internal-bus beat appears on the output.
- R5: A fill that a private burst interrupts continues afterwards with the next word in wrap order and delivers the whole line. This includes a private beat that arrives one clock after the fill's first beat.
- R6: While `priv_en_i` is low, `priv_ready_o` is low and `priv_valid_i` has no effect. No private beat is taken in, so none reaches the output.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output beat and all of its fields stay unchanged.
- R8: Each source's buffer holds `BUF_DEPTH` beats. Its ready output is low exactly when that buffer is full, and no accepted beat is lost.
- R9: `out_src_o` is 0 for internal-bus beats and 1 for private beats. Data and tag pass through unchanged.
- R10: A beat accepted at clock edge k into an empty block is presented on the output right after edge k+1. The output register reloads whenever it is empty or its beat is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_en_i | input | 1 | Enable for the private memory path |
| bus_valid_i | input | 1 | Internal-bus beat valid |
| bus_ready_o | output | 1 | Internal-bus buffer can accept a beat |
| bus_tag_i | input | TAG_W | Transaction tag of the fill |
| bus_start_i | input | IDX_W | Critical word index (used on the first beat of a fill) |
| bus_data_i | input | DATA_W | Internal-bus beat data |
| priv_valid_i | input | 1 | Private-path beat valid |
| priv_ready_o | output | 1 | Private buffer can accept a beat and the path is enabled |
| priv_tag_i | input | TAG_W | Transaction tag of the burst |
| priv_idx_i | input | IDX_W | Word index of the beat |
| priv_last_i | input | 1 | Final beat of the burst |
| priv_data_i | input | DATA_W | Private-path beat data |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Core accepts the output beat |
| out_src_o | output | 1 | Source of the beat: 0 internal bus, 1 private |
| out_tag_o | output | TAG_W | Transaction tag |
| out_idx_o | output | IDX_W | Word index within the line |
| out_last_o | output | 1 | Final beat of the transaction |
| out_data_o | output | DATA_W | Beat data |

## Verification
A lone fill with an odd start index, and the output always ready, checks the wrap order and where the last flag falls without any arbitration involved. The one-clock-offset case checks that a fill displaced after its critical word resumes at the right index instead of stopping early. A run with both buffers filled while the output is stalled separates priority among waiting beats from the order in which they arrived. Random gaps, burst lengths and output stalls, with the private path first disabled and then enabled, check holding, back-pressure and the rule that a burst is never split, in every cycle against the reference model.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  typedef enum logic {
    SRC_BUS  = 1'b0,
    SRC_PRIV = 1'b1
  } src_e;
endpackage

// File: rtl/rrm_fifo.sv
module rrm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CNT_W-1:0] cnt_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_nx;
      if (pop_i)  rptr_q <= rptr_nx;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rrm_fill_tracker.sv
// Position inside the current internal-bus line fill; survives preemption.
module rrm_fill_tracker #(
  parameter int LINE_WORDS = 8,
  parameter int IDX_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IDX_W-1:0] head_start_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] sent_q;
  logic             first;

  assign first  = (sent_q == '0);
  // mod LINE_WORDS by natural IDX_W-bit wrap
  assign idx_o  = first ? head_start_i : start_q + sent_q;
  assign last_o = (sent_q == IDX_W'(LINE_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      sent_q  <= '0;
    end else if (step_i) begin
      if (first) start_q <= head_start_i;
      sent_q <= last_o ? '0 : sent_q + 1'b1;
    end
  end
endmodule

// File: rtl/rrm_arbiter.sv
// Private beats win; an open private burst locks out the bus until its last beat.
module rrm_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bus_avail_i,
  input  logic priv_avail_i,
  input  logic priv_last_i,
  output logic pick_bus_o,
  output logic pick_priv_o
);
  logic lock_q;

  assign pick_priv_o = load_i && priv_avail_i;
  assign pick_bus_o  = load_i && bus_avail_i && !priv_avail_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lock_q <= 1'b0;
    else if (pick_priv_o) lock_q <= !priv_last_i;
  end
endmodule

// File: rtl/rrm_return_merge.sv
module rrm_return_merge #(
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int LINE_WORDS = 8,
  parameter int BUF_DEPTH  = 8,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_en_i,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [IDX_W-1:0]  bus_start_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              priv_valid_i,
  output logic              priv_ready_o,
  input  logic [TAG_W-1:0]  priv_tag_i,
  input  logic [IDX_W-1:0]  priv_idx_i,
  input  logic              priv_last_i,
  input  logic [DATA_W-1:0] priv_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_src_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic              out_last_o,
  output logic [DATA_W-1:0] out_data_o
);
  import rrm_pkg::*;

  localparam int BUS_W  = TAG_W + IDX_W + DATA_W;
  localparam int PRIV_W = TAG_W + IDX_W + 1 + DATA_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [IDX_W-1:0]  start;
    logic [DATA_W-1:0] data;
  } bus_beat_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [DATA_W-1:0] data;
  } priv_beat_t;

  bus_beat_t  bus_in, bus_head;
  priv_beat_t priv_in, priv_head;
  logic bus_empty, bus_full, priv_empty, priv_full;
  logic bus_push, priv_push, pick_bus, pick_priv, load;
  logic [IDX_W-1:0] fill_idx;
  logic fill_last;

  logic              out_valid_q;
  src_e              out_src_q;
  logic [TAG_W-1:0]  out_tag_q;
  logic [IDX_W-1:0]  out_idx_q;
  logic              out_last_q;
  logic [DATA_W-1:0] out_data_q;

  assign bus_in       = '{tag: bus_tag_i, start: bus_start_i, data: bus_data_i};
  assign priv_in      = '{tag: priv_tag_i, idx: priv_idx_i, last: priv_last_i, data: priv_data_i};
  assign bus_ready_o  = !bus_full;
  assign priv_ready_o = priv_en_i && !priv_full;
  assign bus_push     = bus_valid_i && bus_ready_o;
  assign priv_push    = priv_valid_i && priv_ready_o;
  assign load         = !out_valid_q || out_ready_i;

  rrm_fifo #(.W(BUS_W), .DEPTH(BUF_DEPTH)) u_bus_buf (
    .clk_i, .rst_ni,
    .push_i(bus_push), .push_data_i(bus_in), .pop_i(pick_bus),
    .head_o(bus_head), .empty_o(bus_empty), .full_o(bus_full)
  );

  rrm_fifo #(.W(PRIV_W), .DEPTH(BUF_DEPTH)) u_priv_buf (
    .clk_i, .rst_ni,
    .push_i(priv_push), .push_data_i(priv_in), .pop_i(pick_priv),
    .head_o(priv_head), .empty_o(priv_empty), .full_o(priv_full)
  );

  rrm_arbiter u_arb (
    .clk_i, .rst_ni,
    .load_i(load), .bus_avail_i(!bus_empty), .priv_avail_i(!priv_empty),
    .priv_last_i(priv_head.last),
    .pick_bus_o(pick_bus), .pick_priv_o(pick_priv)
  );

  rrm_fill_tracker #(.LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W)) u_fill (
    .clk_i, .rst_ni,
    .step_i(pick_bus), .head_start_i(bus_head.start),
    .idx_o(fill_idx), .last_o(fill_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_src_q   <= SRC_BUS;
      out_tag_q   <= '0;
      out_idx_q   <= '0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
    end else if (load) begin
      out_valid_q <= pick_bus || pick_priv;
      if (pick_priv) begin
        out_src_q  <= SRC_PRIV;
        out_tag_q  <= priv_head.tag;
        out_idx_q  <= priv_head.idx;
        out_last_q <= priv_head.last;
        out_data_q <= priv_head.data;
      end else if (pick_bus) begin
        out_src_q  <= SRC_BUS;
        out_tag_q  <= bus_head.tag;
        out_idx_q  <= fill_idx;
        out_last_q <= fill_last;
        out_data_q <= bus_head.data;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_src_o   = out_src_q;
  assign out_tag_o   = out_tag_q;
  assign out_idx_o   = out_idx_q;
  assign out_last_o  = out_last_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/rrm_return_merge_chk.sv
module rrm_return_merge_chk #(
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int LINE_WORDS = 8,
  parameter int IDX_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              priv_en_i,
  input logic              priv_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_src_o,
  input logic [TAG_W-1:0]  out_tag_o,
  input logic [IDX_W-1:0]  out_idx_o,
  input logic              out_last_o,
  input logic [DATA_W-1:0] out_data_o
);
  logic             acc;
  logic             in_burst_q;
  logic [IDX_W-1:0] exp_idx_q;
  int unsigned      bus_n_q;

  assign acc = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q <= 1'b0;
      exp_idx_q  <= '0;
      bus_n_q    <= 0;
    end else if (acc) begin
      if (out_src_o) begin
        in_burst_q <= !out_last_o;
      end else begin
        exp_idx_q <= out_idx_o + 1'b1;
        bus_n_q   <= out_last_o ? 0 : bus_n_q + 1;
      end
    end
  end

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_src_o, out_tag_o, out_idx_o, out_last_o, out_data_o}));

  assert_priv_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_en_i |-> !priv_ready_o);

  assert_burst_whole_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_burst_q |-> out_src_o);

  assert_fill_resume_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !out_src_o && bus_n_q != 0 |-> out_idx_o == exp_idx_q);

  assert_fill_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !out_src_o |-> out_last_o == (bus_n_q == LINE_WORDS - 1));
endmodule

bind rrm_return_merge rrm_return_merge_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .priv_en_i(priv_en_i), .priv_ready_o(priv_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_src_o(out_src_o),
  .out_tag_o(out_tag_o), .out_idx_o(out_idx_o), .out_last_o(out_last_o),
  .out_data_o(out_data_o)
);

// File: tb/rrm_return_merge_tb_top.sv
`timescale 1ns/1ps
module rrm_return_merge_tb_top;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int LINE   = 8;
  localparam int IDX_W  = 3;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv_en = 1'b1;
  logic bus_valid = 1'b0, priv_valid = 1'b0, priv_last = 1'b0, out_ready = 1'b1;
  logic [TAG_W-1:0] bus_tag = '0, priv_tag = '0;
  logic [IDX_W-1:0] bus_start = '0, priv_idx = '0;
  logic [DATA_W-1:0] bus_data = '0, priv_data = '0;
  logic bus_ready, priv_ready, out_valid, out_src, out_last;
  logic [TAG_W-1:0] out_tag;
  logic [IDX_W-1:0] out_idx;
  logic [DATA_W-1:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit rand_ready = 0;

  always #2 clk = ~clk;

  rrm_return_merge #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LINE_WORDS(LINE), .BUF_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .priv_en_i(priv_en),
    .bus_valid_i(bus_valid), .bus_ready_o(bus_ready), .bus_tag_i(bus_tag),
    .bus_start_i(bus_start), .bus_data_i(bus_data),
    .priv_valid_i(priv_valid), .priv_ready_o(priv_ready), .priv_tag_i(priv_tag),
    .priv_idx_i(priv_idx), .priv_last_i(priv_last), .priv_data_i(priv_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_src_o(out_src),
    .out_tag_o(out_tag), .out_idx_o(out_idx), .out_last_o(out_last), .out_data_o(out_data)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int tag; int start; longint data; } bb_t;
  typedef struct { int tag; int idx; bit last; longint data; } pb_t;
  typedef struct { bit src; int tag; int idx; bit last; } lb_t;
  bb_t bq[$];
  pb_t pq[$];
  lb_t acc_log[$];
  bit m_valid, m_src, m_last, m_lock;
  int m_tag, m_idx, m_cnt, m_start;
  longint m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete(); pq.delete();
      m_valid = 0; m_src = 0; m_last = 0; m_lock = 0;
      m_tag = 0; m_idx = 0; m_cnt = 0; m_start = 0; m_data = 0;
    end else begin
      bit b_rdy, p_rdy;
      b_rdy = bq.size() < DEPTH;
      p_rdy = priv_en && pq.size() < DEPTH;
      if (!m_valid || out_ready) begin
        if (pq.size() > 0) begin
          pb_t p;
          p = pq.pop_front();
          m_valid = 1; m_src = 1; m_tag = p.tag; m_idx = p.idx; m_last = p.last; m_data = p.data;
          m_lock = !p.last;
        end else if (bq.size() > 0 && !m_lock) begin
          bb_t b;
          b = bq.pop_front();
          if (m_cnt == 0) m_start = b.start;
          m_valid = 1; m_src = 0; m_tag = b.tag; m_data = b.data;
          m_idx = (m_start + m_cnt) % LINE;
          m_last = (m_cnt == LINE - 1);
          m_cnt = (m_cnt + 1) % LINE;
        end else begin
          m_valid = 0;
        end
      end
      if (bus_valid && b_rdy) bq.push_back('{int'(bus_tag), int'(bus_start), longint'(bus_data)});
      if (priv_valid && p_rdy) pq.push_back('{int'(priv_tag), int'(priv_idx), priv_last, longint'(priv_data)});
    end
  end

  // compare every cycle, log accepted beats
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R10 valid", out_valid, m_valid);
      check(bus_ready == (bq.size() < DEPTH), "R8 bus_ready", bus_ready, bq.size() < DEPTH);
      check(priv_ready == (priv_en && pq.size() < DEPTH), "R6 priv_ready", priv_ready, priv_en && pq.size() < DEPTH);
      if (m_valid && out_valid) begin
        check(out_src == m_src, "R9 src", out_src, m_src);
        check(out_tag == m_tag, "R9 tag", out_tag, m_tag);
        check(out_data == m_data, "R9 data", out_data, m_data);
        check(out_idx == m_idx, "R2 idx", out_idx, m_idx);
        check(out_last == m_last, "R2 last", out_last, m_last);
      end
      if (out_valid && out_ready) acc_log.push_back('{out_src, int'(out_tag), int'(out_idx), out_last});
      if (rand_ready) out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // ---------------- drivers ----------------
  task automatic send_bus(int tag, int start, int gap);
    for (int n = 0; n < LINE; n++) begin
      bus_valid = 1; bus_tag = TAG_W'(tag); bus_start = IDX_W'(start);
      bus_data = DATA_W'(32'hB000_0000 | (tag << 8) | n);
      forever begin
        if (bus_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
      bus_valid = 0;
      repeat (gap > 0 ? $urandom_range(0, gap) : 0) @(negedge clk);
    end
  endtask

  task automatic send_priv(int tag, int start, int len, int gap);
    for (int n = 0; n < len; n++) begin
      priv_valid = 1; priv_tag = TAG_W'(tag); priv_idx = IDX_W'((start + n) % LINE);
      priv_last = (n == len - 1);
      priv_data = DATA_W'(32'hD000_0000 | (tag << 8) | n);
      forever begin
        if (priv_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
      priv_valid = 0; priv_last = 0;
      repeat (gap > 0 ? $urandom_range(0, gap) : 0) @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (bq.size() == 0 && pq.size() == 0 && !m_valid) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    lb_t e[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(bus_ready == 1, "R1 bus_ready", bus_ready, 1);
    check(priv_ready == priv_en, "R1 priv_ready", priv_ready, priv_en);

    // R2 lone fill, start 3
    acc_log.delete();
    send_bus(1, 3, 0);
    drain();
    check(acc_log.size() == LINE, "R2 beat count", acc_log.size(), LINE);
    for (int n = 0; n < acc_log.size(); n++)
      check(acc_log[n].idx == (3 + n) % LINE && acc_log[n].last == (n == LINE - 1),
            "R2 wrap order", acc_log[n].idx, (3 + n) % LINE);

    // R5 hazard: private beat one clock behind the fill's first beat
    acc_log.delete();
    fork
      send_bus(1, 5, 0);
      begin @(negedge clk); send_priv(2, 0, 4, 0); end
    join
    drain();
    e.push_back('{0, 1, 5, 0});
    for (int n = 0; n < 4; n++) e.push_back('{1, 2, n, n == 3});
    for (int n = 1; n < LINE; n++) e.push_back('{0, 1, (5 + n) % LINE, n == LINE - 1});
    check(acc_log.size() == e.size(), "R5 total beats", acc_log.size(), e.size());
    for (int n = 0; n < e.size() && n < acc_log.size(); n++)
      check(acc_log[n] == e[n], "R5 R4 hazard order", {acc_log[n].src, 8'(acc_log[n].idx)},
            {e[n].src, 8'(e[n].idx)});

    // R3 R8 stall with both buffers loaded
    acc_log.delete();
    out_ready = 0;
    fork
      send_bus(3, 6, 0);
      send_priv(4, 2, 8, 0);
    join
    check(bus_ready == 0, "R8 bus full", bus_ready, 0);
    check(out_valid == 1 && out_src == 1, "R3 private held first", out_src, 1);
    out_ready = 1;
    drain();
    check(acc_log.size() == 16, "R8 nothing lost", acc_log.size(), 16);
    for (int n = 0; n < acc_log.size(); n++)
      check(acc_log[n].src == (n < 8), "R3 private wins", acc_log[n].src, n < 8);

    // R6 private path disabled
    acc_log.delete();
    priv_en = 0;
    fork
      send_bus(5, 1, 2);
      begin
        priv_valid = 1; priv_tag = 6; priv_last = 1;
        repeat (12) begin
          @(negedge clk);
          check(priv_ready == 0, "R6 ready low", priv_ready, 0);
        end
        priv_valid = 0; priv_last = 0;
      end
    join
    drain();
    check(acc_log.size() == LINE, "R6 only bus beats", acc_log.size(), LINE);
    for (int n = 0; n < acc_log.size(); n++)
      check(acc_log[n].src == 0, "R6 no private beat", acc_log[n].src, 0);

    // random traffic, path disabled then enabled (model check covers R7 R9 R10)
    for (int phase = 0; phase < 2; phase++) begin
      priv_en = phase[0];
      rand_ready = 1;
      fork
        for (int i = 0; i < 15; i++) send_bus(i, $urandom_range(0, LINE - 1), 2);
        if (phase == 1) for (int i = 0; i < 20; i++)
          send_priv(i, $urandom_range(0, LINE - 1), $urandom_range(1, LINE), 3);
      join
      rand_ready = 0;
      @(negedge clk);
      out_ready = 1;
      drain();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule